// File: doc/BRIEF.md
# Four-Register Byte-Coded 8-bit Processor Core

This core runs a program of one-byte instructions. It holds four 8-bit general registers, a zero flag and a negative flag, and a 16-bit program counter. Every instruction takes two clock cycles. In the fetch cycle the core presents the program counter on a synchronous instruction port. In the execute cycle the byte returned by that port is decoded and retired.

Loads and stores go through a data port. A data address is formed from a fixed page byte and the 8-bit sum of a base register and a small displacement. One address in that page is an output register that drives LEDs instead of memory. The instruction set covers register and immediate arithmetic, NAND, shift, invert, clear, flag-conditioned skips, signed relative branches and a jump-and-link that swaps the program counter's low byte with r0. A branch to itself is the idle loop that ends a program.

Top module: `tiny8_core`

## Requirements
- R1: Reset is synchronous and active high. After reset the program counter is 0x8000, all registers and both flags are 0, the LED register is 0, and the first fetch presents address 0x8000.
- R2: The core alternates between two cycles. In the fetch cycle `imem_en` is high and `imem_addr` carries the program counter. In the following execute cycle the core executes the byte on `imem_data`.
- R3: Load, byte `00 dd b kkk`, writes register dd with `dmem_rdata` and raises `dmem_re`. The address is {0xC0, base+kkk}, where base is r2 when b=0 and r3 when b=1, and the sum wraps at 8 bits.
- R4: Store, byte `01 ss b kkk`, drives register ss on `dmem_wdata` and raises `dmem_we` at the address formed as in R3. `dmem_we` and `dmem_re` are never high together.
- R5: A store whose address is 0xC000 loads the LED register and leaves `dmem_we` low, so memory is not written.
- R6: Add-immediate, byte `10 dd iiii`, adds the zero-extended 4-bit value to register dd, modulo 256.
- R7: Byte `11 aa bb ff` with ff=00 sets ra to ra+rb (mod 256). With ff=01 it sets ra to NOT(ra AND rb).
- R8: With ff=10 and bb=00 the core shifts ra left by one and fills bit 0 with 0. With bb=01 it inverts ra. With bb=10 it clears ra.
- R9: The operations of R6 to R8 set Z to (result==0) and N to result bit 7. All other instructions leave both flags unchanged.
- R10: Byte 0xEE skips the next instruction when N=1, and byte 0xFE skips it when Z=1. A skip advances the program counter by 2 when taken and by 1 otherwise. Byte 0xCE does nothing.
- R11: Byte 0xDE (jump-and-link) loads the program counter's low byte from r0 and keeps its high byte. In the same cycle it writes the low byte of the program counter plus one into r0.
- R12: Byte `11 oooo 11` adds the signed 4-bit offset oooo to the branch's own address. An offset of 0 repeats the branch forever.
- R13: Every other instruction advances the 16-bit program counter by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_en | output | 1 | Instruction read strobe, high in fetch cycles |
| imem_addr | output | 16 | Instruction address (program counter) |
| imem_data | input | 8 | Instruction byte, valid the cycle after `imem_en` |
| dmem_addr | output | 16 | Data address |
| dmem_wdata | output | 8 | Store data |
| dmem_rdata | input | 8 | Load data, read combinationally |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| led | output | 8 | Memory-mapped LED register |

## Verification
Jump-and-link is the one instruction that reads and writes both r0 and the program counter in a single execute cycle. The old r0 must become the jump target while the return byte lands in r0. A directed program loads a target into r0, jumps, and stores r0 afterwards. The bench judges the swap by the stored return value and by the fact that the skipped bytes never run. The second case falls inside a store: the address compare decides between the LED register and the memory strobe in the same cycle. This is judged by the LED value together with the untouched memory byte at offset 0. Constrained random programs mix both with the arithmetic, skip and load/store paths against an instruction-level model kept in the bench.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

    localparam int DW        = 8;
    localparam int AW        = 16;
    localparam int NREG      = 4;
    localparam int RIDX      = $clog2(NREG);
    localparam int NRD       = 3;

    typedef enum logic [3:0] {
        OP_LOAD, OP_STORE, OP_ADDI, OP_ADD, OP_NAND, OP_SHL, OP_NOT, OP_CLR,
        OP_JAL, OP_SKIPN, OP_SKIPZ, OP_NOP, OP_BRANCH
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [RIDX-1:0]  ra;
        logic [RIDX-1:0]  rb;
        logic             base_hi;
        logic [2:0]       disp;
        logic [3:0]       imm;
        logic [3:0]       boff;
    } instr_t;

    typedef struct packed {
        logic z;
        logic n;
    } flags_t;

    typedef enum logic {S_FETCH, S_EXEC} phase_e;

    function automatic instr_t decode_byte(input logic [7:0] b);
        instr_t d;
        d.ra      = b[5:4];
        d.rb      = b[3:2];
        d.base_hi = b[3];
        d.disp    = b[2:0];
        d.imm     = b[3:0];
        d.boff    = b[5:2];
        unique case (b[7:6])
            2'b00: d.op = OP_LOAD;
            2'b01: d.op = OP_STORE;
            2'b10: d.op = OP_ADDI;
            default: begin
                unique case (b[1:0])
                    2'b00: d.op = OP_ADD;
                    2'b01: d.op = OP_NAND;
                    2'b11: d.op = OP_BRANCH;
                    default: begin
                        unique case (b[3:2])
                            2'b00: d.op = OP_SHL;
                            2'b01: d.op = OP_NOT;
                            2'b10: d.op = OP_CLR;
                            default: begin
                                unique case (b[5:4])
                                    2'b01:   d.op = OP_JAL;
                                    2'b10:   d.op = OP_SKIPN;
                                    2'b11:   d.op = OP_SKIPZ;
                                    default: d.op = OP_NOP;
                                endcase
                            end
                        endcase
                    end
                endcase
            end
        endcase
        return d;
    endfunction

    function automatic logic sets_flags(input op_e op);
        return (op == OP_ADDI) || (op == OP_ADD) || (op == OP_NAND) ||
               (op == OP_SHL)  || (op == OP_NOT) || (op == OP_CLR);
    endfunction

endpackage

// File: rtl/tiny8_decode.sv
module tiny8_decode
    import tiny8_pkg::*;
(
    input  logic [7:0] ibyte,
    output instr_t     dec
);
    always_comb dec = decode_byte(ibyte);
endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu
    import tiny8_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [3:0]    imm,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (op)
            OP_ADDI: y = a + {{(DW-4){1'b0}}, imm};
            OP_ADD:  y = a + b;
            OP_NAND: y = ~(a & b);
            OP_SHL:  y = {a[DW-2:0], 1'b0};
            OP_NOT:  y = ~a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/tiny8_regfile.sv
module tiny8_regfile
    import tiny8_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [RIDX-1:0]          waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][RIDX-1:0] raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = regs[raddr[p]];
    end

    assert_rf_write_R7: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
    import tiny8_pkg::*;
#(
    parameter logic [15:0] RESET_PC  = 16'h8000,
    parameter logic [7:0]  DATA_PAGE = 8'hC0
) (
    input  logic          clk,
    input  logic          rst,
    output logic          imem_en,
    output logic [15:0]   imem_addr,
    input  logic [7:0]    imem_data,
    output logic [15:0]   dmem_addr,
    output logic [7:0]    dmem_wdata,
    input  logic [7:0]    dmem_rdata,
    output logic          dmem_we,
    output logic          dmem_re,
    output logic [7:0]    led
);
    localparam logic [AW-1:0] LED_ADDR = {DATA_PAGE, 8'h00};

    phase_e                    phase;
    logic [AW-1:0]             pc, pc_next;
    flags_t                    flags;
    instr_t                    dec;
    logic [DW-1:0]             alu_y;
    logic [NRD-1:0][RIDX-1:0]  raddr;
    logic [NRD-1:0][DW-1:0]    rdata;
    logic                      rf_we;
    logic [RIDX-1:0]           rf_waddr;
    logic [DW-1:0]             rf_wdata;
    logic                      exec, is_led, skip_hit;
    logic [DW-1:0]             ea_low;

    tiny8_decode u_dec (.ibyte(imem_data), .dec(dec));

    assign raddr[0] = dec.ra;
    assign raddr[1] = (dec.op == OP_JAL) ? RIDX'(0) : dec.rb;
    assign raddr[2] = {1'b1, dec.base_hi};

    tiny8_regfile u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
        .raddr(raddr), .rdata(rdata)
    );

    tiny8_alu u_alu (.op(dec.op), .a(rdata[0]), .b(rdata[1]), .imm(dec.imm), .y(alu_y));

    assign exec       = (phase == S_EXEC);
    assign ea_low     = rdata[2] + {{(DW-3){1'b0}}, dec.disp};
    assign dmem_addr  = {DATA_PAGE, ea_low};
    assign dmem_wdata = rdata[0];
    assign is_led     = (dmem_addr == LED_ADDR);
    assign dmem_re    = exec && (dec.op == OP_LOAD);
    assign dmem_we    = exec && (dec.op == OP_STORE) && !is_led;
    assign imem_en    = (phase == S_FETCH);
    assign imem_addr  = pc;
    assign skip_hit   = ((dec.op == OP_SKIPN) && flags.n) || ((dec.op == OP_SKIPZ) && flags.z);

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = dec.ra;
        rf_wdata = alu_y;
        if (exec) begin
            if (dec.op == OP_LOAD) begin
                rf_we    = 1'b1;
                rf_wdata = dmem_rdata;
            end else if (sets_flags(dec.op)) begin
                rf_we    = 1'b1;
            end else if (dec.op == OP_JAL) begin
                rf_we    = 1'b1;
                rf_waddr = '0;
                rf_wdata = pc[7:0] + 8'd1;
            end
        end
    end

    always_comb begin
        unique case (dec.op)
            OP_JAL:    pc_next = {pc[AW-1:8], rdata[1]};
            OP_BRANCH: pc_next = pc + {{(AW-4){dec.boff[3]}}, dec.boff};
            default:   pc_next = pc + (skip_hit ? 16'd2 : 16'd1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= S_FETCH;
            pc    <= RESET_PC;
            flags <= '0;
            led   <= '0;
        end else if (phase == S_FETCH) begin
            phase <= S_EXEC;
        end else begin
            phase <= S_FETCH;
            pc    <= pc_next;
            if (sets_flags(dec.op)) flags <= '{z: (alu_y == '0), n: alu_y[DW-1]};
            if ((dec.op == OP_STORE) && is_led) led <= rdata[0];
        end
    end

    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_addr == RESET_PC) && imem_en && (led == '0));
    assert_fetch_exec_R2: assert property (@(posedge clk) disable iff (rst)
        imem_en |=> !imem_en);
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(dmem_we && dmem_re));
    assert_led_store_R5: assert property (@(posedge clk) disable iff (rst)
        (exec && dec.op == OP_STORE && !dmem_we) |=> led == $past(dmem_wdata));
    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (exec && !sets_flags(dec.op)) |=> $stable(flags));
    assert_halt_R12: assert property (@(posedge clk) disable iff (rst)
        (exec && dec.op == OP_BRANCH && dec.boff == 4'd0) |=> $stable(imem_addr));
    assert_step_R13: assert property (@(posedge clk) disable iff (rst)
        (exec && (dec.op == OP_ADD || dec.op == OP_LOAD || dec.op == OP_STORE)) |=>
        imem_addr == $past(imem_addr) + 16'd1);
endmodule

// File: tb/tiny8_core_test.sv
`timescale 1ns/1ps
module tiny8_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imem_en, dmem_we, dmem_re;
    logic [15:0] imem_addr, dmem_addr;
    logic [7:0]  imem_data, dmem_wdata, dmem_rdata, led;

    logic [7:0] rom [256];
    logic [7:0] ram [256];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    tiny8_core uut (
        .clk(clk), .rst(rst), .imem_en(imem_en), .imem_addr(imem_addr),
        .imem_data(imem_data), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .dmem_we(dmem_we), .dmem_re(dmem_re), .led(led)
    );

    always @(posedge clk) if (imem_en) imem_data <= rom[imem_addr[7:0]];
    assign dmem_rdata = ram[dmem_addr[7:0]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) ram[i] <= 8'h00;
        end else if (dmem_we) begin
            ram[dmem_addr[7:0]] <= dmem_wdata;
        end
    end

    // bench-side instruction model
    logic [7:0]  m_r [4];
    logic [7:0]  m_ram [256];
    logic [7:0]  m_led;
    logic [15:0] m_pc;
    bit          m_z, m_n;
    int          m_steps;

    function automatic logic [7:0] e_mem(input logic [1:0] op, input int r, input int b, input int k);
        return {op, 2'(r), 1'(b), 3'(k)};
    endfunction
    function automatic logic [7:0] e_addi(input int r, input int v); return {2'b10, 2'(r), 4'(v)}; endfunction
    function automatic logic [7:0] e_rr(input int a, input int b, input int f); return {2'b11, 2'(a), 2'(b), 2'(f)}; endfunction
    function automatic logic [7:0] e_br(input int off); return {2'b11, 4'(off), 2'b11}; endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic m_flags(input logic [7:0] v);
        m_z = (v == 8'h00);
        m_n = v[7];
    endtask

    task automatic m_step(output bit halt);
        logic [7:0] ir, addr, v;
        int a, b;
        ir = rom[m_pc[7:0]];
        a = ir[5:4];
        b = ir[3:2];
        halt = 0;
        m_steps++;
        addr = m_r[ir[3] ? 3 : 2] + {5'd0, ir[2:0]};
        case (ir[7:6])
            2'b00: begin m_r[a] = m_ram[addr]; m_pc++; end
            2'b01: begin
                if (addr == 8'h00) m_led = m_r[a]; else m_ram[addr] = m_r[a];
                m_pc++;
            end
            2'b10: begin m_r[a] = m_r[a] + {4'd0, ir[3:0]}; m_flags(m_r[a]); m_pc++; end
            default: begin
                if (ir[1:0] == 2'b00) begin m_r[a] = m_r[a] + m_r[b]; m_flags(m_r[a]); m_pc++; end
                else if (ir[1:0] == 2'b01) begin m_r[a] = ~(m_r[a] & m_r[b]); m_flags(m_r[a]); m_pc++; end
                else if (ir[1:0] == 2'b11) begin
                    if (ir[5:2] == 4'd0) halt = 1;
                    m_pc = m_pc + {{12{ir[5]}}, ir[5:2]};
                end else if (b != 3) begin
                    v = (b == 0) ? {m_r[a][6:0], 1'b0} : (b == 1) ? ~m_r[a] : 8'h00;
                    m_r[a] = v; m_flags(v); m_pc++;
                end else if (a == 1) begin
                    v = m_r[0];
                    m_r[0] = m_pc[7:0] + 8'd1;
                    m_pc = {m_pc[15:8], v};
                end else if ((a == 2 && m_n) || (a == 3 && m_z)) m_pc = m_pc + 16'd2;
                else m_pc++;
            end
        endcase
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = e_br(0);
    endtask

    task automatic run_prog(input string req);
        bit h;
        int bad, first;
        for (int i = 0; i < 4; i++) m_r[i] = 0;
        for (int i = 0; i < 256; i++) m_ram[i] = 0;
        m_led = 0; m_pc = 16'h8000; m_z = 0; m_n = 0; m_steps = 0;
        h = 0;
        while (!h && m_steps < 400) m_step(h);
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
        repeat (2 * m_steps + 6) @(negedge clk);
        #1;
        bad = 0; first = -1;
        for (int i = 0; i < 256; i++) if (ram[i] !== m_ram[i]) begin bad++; if (first < 0) first = i; end
        if (first >= 0) chk({req, " ram"}, {24'd0, ram[first]}, {24'd0, m_ram[first]});
        else chk({req, " ram"}, 0, 0);
        chk({req, " led"}, {24'd0, led}, {24'd0, m_led});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] op;
        int k;
        void'($urandom(32'd20240611));
        clear_rom();
        // R1 reset state
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1 fetch addr", {16'd0, imem_addr}, 32'h8000);
        chk("R1 led", {24'd0, led}, 0);
        chk("R2 fetch strobe", {31'd0, imem_en}, 1);
        @(negedge clk); #1;
        chk("R2 exec phase", {31'd0, imem_en}, 0);

        // loop, skipz, branch back, store/load, LED store (R3 R4 R5 R8 R10 R12)
        clear_rom();
        rom[0] = e_rr(2,2,2); rom[1] = e_rr(3,2,2); rom[2] = e_rr(1,2,2);
        rom[3] = e_addi(1,1); rom[4] = e_addi(3,15);
        for (int i = 5; i < 9; i++) rom[i] = e_rr(3,0,2);
        rom[9] = e_addi(3,14); rom[10] = e_rr(2,3,0);
        rom[11] = e_rr(3,1,0); rom[12] = 8'hFE; rom[13] = e_br(-2);
        rom[14] = e_addi(3,1); rom[15] = e_rr(3,1,2);
        rom[16] = e_mem(2'b01,3,0,0); rom[17] = e_rr(3,2,2);
        rom[18] = e_mem(2'b00,3,0,0); rom[19] = e_mem(2'b01,3,0,1);
        rom[20] = e_rr(2,2,2); rom[21] = e_mem(2'b01,3,0,0);
        run_prog("R12 loop");
        chk("R4 store FE", {24'd0, ram[8'hFE]}, 32'hFE);
        chk("R3 load back", {24'd0, ram[8'hFF]}, 32'hFE);
        chk("R5 led value", {24'd0, led}, 32'hFE);
        chk("R5 no ram at page offset 0", {24'd0, ram[0]}, 0);

        // jump-and-link, skipn, skipz not taken, nop, forward branch (R9 R10 R11 R12)
        clear_rom();
        rom[0] = e_rr(0,2,2); rom[1] = e_addi(0,8); rom[2] = 8'hDE;
        for (int i = 3; i < 8; i++) rom[i] = e_addi(1,1);
        rom[8] = e_rr(3,2,2); rom[9] = e_mem(2'b01,0,1,1); rom[10] = e_mem(2'b01,1,1,2);
        rom[11] = e_rr(2,2,2); rom[12] = e_rr(2,1,2); rom[13] = 8'hEE; rom[14] = e_addi(1,5);
        rom[15] = e_mem(2'b01,1,1,3); rom[16] = 8'hFE; rom[17] = e_addi(1,3);
        rom[18] = e_mem(2'b01,1,1,4); rom[19] = 8'hCE; rom[20] = e_br(2);
        rom[21] = e_addi(1,1); rom[22] = e_mem(2'b01,1,1,5);
        run_prog("R11 jal");
        chk("R11 return byte in r0", {24'd0, ram[1]}, 32'h03);
        chk("R11 skipped bytes not run", {24'd0, ram[2]}, 0);
        chk("R10 skipn taken", {24'd0, ram[3]}, 0);
        chk("R10 skipz not taken", {24'd0, ram[4]}, 3);
        chk("R12 forward branch", {24'd0, ram[5]}, 3);

        // constrained random programs (R3 R4 R5 R6 R7 R8 R9 R10 R13)
        for (int p = 0; p < 30; p++) begin
            clear_rom();
            for (int i = 0; i < 28; i++) begin
                k = $urandom % 10;
                case (k)
                    0: op = e_mem(2'b00, $urandom%4, $urandom%2, $urandom%8);
                    1: op = e_mem(2'b01, $urandom%4, $urandom%2, $urandom%8);
                    2, 3: op = e_addi($urandom%4, $urandom%16);
                    4: op = e_rr($urandom%4, $urandom%4, 0);
                    5: op = e_rr($urandom%4, $urandom%4, 1);
                    6: op = e_rr($urandom%4, $urandom%3, 2);
                    7: op = 8'hEE;
                    8: op = 8'hFE;
                    default: op = 8'hCE;
                endcase
                rom[i] = op;
            end
            rom[28] = e_rr(3,2,2);
            rom[29] = e_mem(2'b01,0,1,1); rom[30] = e_mem(2'b01,1,1,2);
            rom[31] = e_mem(2'b01,2,1,3); rom[32] = e_mem(2'b01,0,1,0);
            run_prog("R7 R9 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule